// File: doc/BRIEF.md
# Mode-Banked Register File with Program Counter

This block is the general register storage of a small 32-bit RISC core. Software sees sixteen registers, numbered 0 to 15. Behind them sit 31 physical words. A mode register inside the file decides which physical word each architectural number reaches, so that an exception handler gets a private stack pointer and link register without saving the interrupted program's copies. Number 15 is the program counter. Number 14 holds return addresses and number 13 is the stack pointer.

Two combinational read ports and one clocked write port share a 4-bit register number. A separate increment strobe advances the program counter by four for sequential fetch. The program counter is a single word common to every mode. The decoder loads the mode register with a strobe and a 3-bit code. The current mode is visible on an output. A fast-interrupt handler gets private copies of numbers 8 to 14. Each of the other exception modes gets private copies of numbers 13 and 14 only.

Top module: `banked_regfile`

## Requirements
- R1: While rst_n is low, and after it is released, the program counter reads 0, the mode output reads 3 (supervisor), and every register number reads 0 in every mode.
- R2: A word written with wr_en at a clock edge can be read on both read ports from the next cycle onwards, in the mode that was current at that edge.
- R3: Register numbers 0 to 7 reach one shared word each in every mode.
- R4: In mode code 1 (fast interrupt), numbers 8 to 14 reach seven private words. Writes made in that mode leave the words seen by the other modes at those numbers unchanged, and writes made in other modes leave those seven private words unchanged.
- R5: Mode codes 2 (interrupt), 3 (supervisor), 4 (abort) and 5 (undefined) each have two private words at numbers 13 and 14. Numbers 8 to 12 in these modes reach the same words as mode 0.
- R6: Mode code 0 is user. Codes 6 and 7 select exactly the same words as code 0.
- R7: pc_inc adds 4 to the program counter at the clock edge. Number 15 on either read port and pc_out all show the program counter, and its value is the same in every mode.
- R8: When wr_en with wr_idx = 15 and pc_inc fall in the same cycle, the program counter takes wr_data and the increment is dropped.
- R9: A read of a number being written in the same cycle returns the value held before the edge. This includes number 15 while it is being incremented.
- R10: mode_ld loads mode_in into the mode register at the clock edge. A write in that same cycle goes to the word selected by the old mode. Without mode_ld the mode holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ld | input | 1 | Load mode_in into the mode register |
| mode_in | input | 3 | New mode code |
| mode_out | output | 3 | Current mode code |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Register number for the write |
| wr_data | input | 32 | Write data |
| pc_inc | input | 1 | Advance the program counter by four |
| pc_out | output | 32 | Current program counter |

## Verification
Two operations can collide in one cycle. The first is an explicit write of number 15 together with a sequential increment. The second is a write together with a mode load, which raises the question of which bank the write lands in. The bench drives each pair deliberately in the same cycle. It then judges the program counter against the written value rather than the incremented one, and reads the old mode's bank and the new mode's bank to find where the written word went. Same-cycle read-during-write is also provoked on both an ordinary register and the incrementing program counter, and the read must show the pre-edge value.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DATA_W = 32,
  parameter int PC_STEP = 4,
  parameter logic [DATA_W-1:0] PC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic [2:0]        mode_in,
  output logic [2:0]        mode_out,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_inc,
  output logic [DATA_W-1:0] pc_out
);
  localparam int NPHYS = 31;
  localparam int PW = $clog2(NPHYS);
  localparam int PC_SLOT = 15;
  localparam logic [2:0] M_FIQ = 3'd1;
  localparam logic [2:0] M_IRQ = 3'd2;
  localparam logic [2:0] M_SVC = 3'd3;
  localparam logic [2:0] M_ABT = 3'd4;
  localparam logic [2:0] M_UND = 3'd5;

  function automatic logic [PW-1:0] slot(input logic [2:0] m, input logic [3:0] i);
    logic [PW-1:0] s;
    s = PW'(i);
    if (m == M_FIQ && i >= 4'd8 && i <= 4'd14)
      s = PW'(i) + PW'(8);
    else if (i == 4'd13 || i == 4'd14) begin
      case (m)
        M_IRQ:   s = PW'(i) + PW'(10);
        M_SVC:   s = PW'(i) + PW'(12);
        M_ABT:   s = PW'(i) + PW'(14);
        M_UND:   s = PW'(i) + PW'(16);
        default: s = PW'(i);
      endcase
    end
    return s;
  endfunction

  logic [DATA_W-1:0] regs [NPHYS];
  logic [2:0]        mode_q;
  logic [PW-1:0]     wr_slot;

  assign wr_slot = slot(mode_q, wr_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_SVC;
      for (int p = 0; p < NPHYS; p++)
        regs[p] <= (p == PC_SLOT) ? PC_RESET : '0;
    end else begin
      if (mode_ld) mode_q <= mode_in;
      for (int p = 0; p < NPHYS; p++) begin
        if (wr_en && wr_slot == PW'(p))
          regs[p] <= wr_data;
        else if (p == PC_SLOT && pc_inc)
          regs[p] <= regs[p] + DATA_W'(PC_STEP);
      end
    end
  end

  assign rd_a_data = regs[slot(mode_q, rd_a_idx)];
  assign rd_b_data = regs[slot(mode_q, rd_b_idx)];
  assign pc_out    = regs[PC_SLOT];
  assign mode_out  = mode_q;
endmodule

module banked_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int PC_STEP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_ld,
  input logic [2:0]        mode_in,
  input logic [2:0]        mode_out,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              pc_inc,
  input logic [DATA_W-1:0] pc_out
);
  logic pc_wr;
  assign pc_wr = wr_en && wr_idx == 4'd15;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !pc_wr) |=> pc_out == $past(pc_out) + DATA_W'(PC_STEP)); // R7
  AST_PC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |=> pc_out == $past(wr_data)); // R8
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_inc && !pc_wr) |=> $stable(pc_out)); // R7
  AST_READ_A_PC: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 4'd15 |-> rd_a_data == pc_out); // R7
  AST_READ_B_PC: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_idx == 4'd15 |-> rd_b_data == pc_out); // R7
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ld |=> mode_out == $past(mode_in)); // R10
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ld |=> $stable(mode_out)); // R10
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) u_chk (.*);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_ld = 1'b0;
  logic [2:0]    mode_in = '0;
  logic [2:0]    mode_out;
  logic [3:0]    rd_a_idx = '0;
  logic [DW-1:0] rd_a_data;
  logic [3:0]    rd_b_idx = '0;
  logic [DW-1:0] rd_b_data;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic          pc_inc = 1'b0;
  logic [DW-1:0] pc_out;

  banked_regfile u_banked_regfile (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0] mdl [31];
  logic [2:0]    mdl_mode;
  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;

  function automatic int map(input logic [2:0] m, input int i);
    if (i < 8 || i == 15) return i;
    if (m == 3'd1) return i + 8;
    if (i < 13) return i;
    if (m >= 3'd2 && m <= 3'd5) return 23 + 2 * (int'(m) - 2) + (i - 13);
    return i;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic we, input int widx, input logic [DW-1:0] wd,
                      input logic ld, input logic [2:0] min, input logic inc);
    wr_en = we; wr_idx = 4'(widx); wr_data = wd;
    mode_ld = ld; mode_in = min; pc_inc = inc;
    @(posedge clk);
    if (inc && !(we && widx == 15)) mdl[15] = mdl[15] + 4;
    if (we) mdl[map(mdl_mode, widx)] = wd;
    if (ld) mdl_mode = min;
    @(negedge clk);
    wr_en = 1'b0; mode_ld = 1'b0; pc_inc = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int m = 0; m < 8; m++) begin
      tick(1'b0, 0, '0, 1'b1, 3'(m), 1'b0);
      check({tag, " R10 mode"}, {29'd0, mode_out}, DW'(m));
      for (int i = 0; i < 16; i++) begin
        rd_a_idx = 4'(i);
        rd_b_idx = 4'(15 - i);
        #1;
        check({tag, " portA"}, rd_a_data, mdl[map(3'(m), i)]);
        check({tag, " portB"}, rd_b_data, mdl[map(3'(m), 15 - i)]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 31; p++) mdl[p] = '0;
    mdl_mode = 3'd3;
    repeat (3) @(negedge clk);
    #1;
    check("R1 mode in reset", {29'd0, mode_out}, 32'd3);
    check("R1 pc in reset", pc_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 mode after reset", {29'd0, mode_out}, 32'd3);
    check("R1 pc after reset", pc_out, '0);
    read_all("R1");

    for (int m = 0; m < 8; m++) begin
      tick(1'b0, 0, '0, 1'b1, 3'(m), 1'b0);
      for (int i = 0; i < 15; i++)
        tick(1'b1, i, {8'hA5, 8'(m), 8'(i), 8'h3C}, 1'b0, 3'd0, 1'b0);
    end
    read_all("R2 R3 R4 R5 R6 fwd");

    for (int m = 7; m >= 0; m--) begin
      tick(1'b0, 0, '0, 1'b1, 3'(m), 1'b0);
      for (int i = 14; i >= 0; i--)
        tick(1'b1, i, {8'h5A, 8'(i), 8'(m), 8'hC3}, 1'b0, 3'd0, 1'b0);
    end
    read_all("R2 R3 R4 R5 R6 rev");

    tick(1'b0, 0, '0, 1'b1, 3'd0, 1'b0);
    for (int k = 0; k < 10; k++) begin
      tick(1'b0, 0, '0, 1'b0, 3'd0, 1'b1);
      check("R7 increment", pc_out, mdl[15]);
    end
    for (int m = 0; m < 8; m++) begin
      tick(1'b0, 0, '0, 1'b1, 3'(m), 1'b0);
      rd_a_idx = 4'd15; rd_b_idx = 4'd15;
      #1;
      check("R7 portA pc", rd_a_data, mdl[15]);
      check("R7 portB pc", rd_b_data, mdl[15]);
    end

    tick(1'b1, 15, 32'h0000_1000, 1'b0, 3'd0, 1'b1);
    check("R8 write beats increment", pc_out, 32'h0000_1000);
    tick(1'b0, 0, '0, 1'b0, 3'd0, 1'b1);
    check("R8 increment after write", pc_out, 32'h0000_1004);
    tick(1'b1, 15, 32'hFFFF_FFFC, 1'b0, 3'd0, 1'b0);
    tick(1'b0, 0, '0, 1'b0, 3'd0, 1'b1);
    check("R7 wrap", pc_out, 32'h0000_0000);

    tick(1'b0, 0, '0, 1'b1, 3'd2, 1'b0);
    wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hDEAD_0014;
    rd_a_idx = 4'd14; rd_b_idx = 4'd15; pc_inc = 1'b1;
    #1;
    check("R9 old value port A", rd_a_data, mdl[map(3'd2, 14)]);
    check("R9 old pc port B", rd_b_data, mdl[15]);
    @(posedge clk);
    mdl[map(3'd2, 14)] = 32'hDEAD_0014;
    mdl[15] = mdl[15] + 4;
    @(negedge clk);
    wr_en = 1'b0; pc_inc = 1'b0;
    #1;
    check("R9 new value port A", rd_a_data, 32'hDEAD_0014);
    check("R9 new pc port B", rd_b_data, mdl[15]);

    tick(1'b0, 0, '0, 1'b1, 3'd0, 1'b0);
    tick(1'b1, 13, 32'hBEEF_0D13, 1'b1, 3'd1, 1'b0);
    check("R10 mode loaded", {29'd0, mode_out}, 32'd1);
    rd_a_idx = 4'd13;
    #1;
    check("R10 fiq bank untouched", rd_a_data, mdl[map(3'd1, 13)]);
    for (int k = 0; k < 3; k++) begin
      tick(1'b0, 0, '0, 1'b0, 3'd5, 1'b0);
      check("R10 mode held", {29'd0, mode_out}, 32'd1);
    end
    tick(1'b0, 0, '0, 1'b1, 3'd0, 1'b0);
    rd_a_idx = 4'd13;
    #1;
    check("R10 write used old mode", rd_a_data, 32'hBEEF_0D13);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule